// File: doc/BRIEF.md
# Backup-Mode Wake-Up Controller

This block decides when a device sleeping in its deepest low-power state should come back to life. It monitors sixteen external wake pins and three internal alarm lines: the real-time clock, the real-time timer and the supply monitor. It runs entirely on the slow clock.

Each pin has an enable and a polarity choice. A pin counts as a wake event only after it has made a transition to its selected level and then held that level for a programmable number of slow-clock cycles. Each alarm line is gated by its own enable. A sticky status vector remembers every source that produced an event.

Any qualified event starts a restart sequence toward the supply controller. The sequence requests the core supply first and waits a fixed settle time. It then requests the SRAM supply and signals completion. A supply that is already reported as on is never requested again.

Top module: `wk_backup_ctrl`

## Requirements
- R1: During and right after reset, `wake_status` is all zero and `core_on_req`, `sram_on_req` and `restart_done` are low.
- R2: With `wk_pin_en[i]=1` and `wk_rise_sel[i]=1`, a low-to-high change on `wk_pin[i]` is a wake event, and it sets `wake_status[i]`.
- R3: With `wk_rise_sel[i]=0`, only a high-to-low change on `wk_pin[i]` is a wake event.
- R4: A pin event is accepted only on the clock where the pin has been sampled at its target level for 2^`dbc_sel` consecutive slow-clock edges. If the pin leaves the target level earlier, the count restarts. `dbc_sel=0` accepts the first sample. `wake_status[i]` rises one edge after acceptance.
- R5: A pin that already sits at its target level after reset, or when it is enabled, produces no event until it has first been sampled at the opposite level. A pin held at its target level produces only one event.
- R6: The alarm inputs map to status bits as follows: `rtc_alarm` to bit 16, `rtt_alarm` to bit 17 and `sm_alarm` to bit 18. While its enable is high, an asserted alarm sets its status bit on the next edge and triggers a restart.
- R7: A disabled pin or alarm is ignored. It never sets a status bit and never starts a restart.
- R8: Status bits stay set until `stat_clr` is high at a clock edge. An event in that same edge still sets its bit.
- R9: When a wake event arrives while idle with the core supply off, the sequence runs as follows. `core_on_req` pulses for one cycle. After `SETTLE_CYC` further cycles plus one, `sram_on_req` pulses together with `restart_done`.
- R10: If `core_is_on` is high when a restart begins, there is no core request and no settle wait. If `sram_is_on` is high in the final step, there is no SRAM request, but `restart_done` still pulses.
- R11: Events that arrive while a sequence is running still set status bits, but they neither restart nor extend the running sequence. Each sequence gives exactly one `restart_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| wk_pin | input | 16 | External wake pins |
| wk_pin_en | input | 16 | Per-pin enable |
| wk_rise_sel | input | 16 | Per-pin polarity: 1 selects rising, 0 selects falling |
| dbc_sel | input | 3 | Debounce length exponent (2^n samples) |
| rtc_alarm | input | 1 | Real-time clock alarm |
| rtt_alarm | input | 1 | Real-time timer alarm |
| sm_alarm | input | 1 | Supply monitor alarm |
| rtc_en | input | 1 | Gate for rtc_alarm |
| rtt_en | input | 1 | Gate for rtt_alarm |
| sm_en | input | 1 | Gate for sm_alarm |
| stat_clr | input | 1 | Clears the sticky status |
| core_is_on | input | 1 | Core supply already on |
| sram_is_on | input | 1 | SRAM supply already on |
| wake_status | output | 19 | Sticky per-source flags |
| core_on_req | output | 1 | Core supply request pulse |
| sram_on_req | output | 1 | SRAM supply request pulse |
| restart_done | output | 1 | Sequence complete pulse |

## Verification
Each pin carries a run counter. If that counter drifts, `wake_status` flips one edge too early or too late. If it fails to saturate, a held pin fires a second time, and that shows up as a second `restart_done` a few cycles later. A fault in the sequencer state shows as a missing, doubled or misplaced request pulse within `SETTLE_CYC+2` cycles of the triggering event. A wrong clear or gating decision shows on the status vector at the very next edge.

// File: rtl/wk_pkg.sv
package wk_pkg;
    localparam int WK_PINS   = 16;
    localparam int WK_ALARMS = 3;
    localparam int WK_SRC    = WK_PINS + WK_ALARMS;
    localparam int DBC_W     = 3;
    // longest run is 2^(2^DBC_W-1); one extra bit leaves room for a saturation value
    localparam int CNT_W     = (1 << DBC_W);
    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SETTLE,
        SQ_SRAM
    } seq_state_t;

    typedef struct packed {
        logic en;
        logic rise;
    } pin_cfg_t;

    typedef struct packed {
        logic sm;
        logic rtt;
        logic rtc;
    } alarm_vec_t;

    function automatic logic [CNT_W-1:0] dbc_last(input logic [DBC_W-1:0] sel);
        return (CNT_W'(1) << sel) - CNT_W'(1);
    endfunction
endpackage

// File: rtl/wk_pin_qual.sv
module wk_pin_qual
    import wk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pin,
    input  pin_cfg_t         cfg,
    input  logic [DBC_W-1:0] dbc_sel,
    output logic             evt
);
    logic [CNT_W-1:0] run_cnt;
    logic             at_tgt;

    assign at_tgt = (pin == cfg.rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= CNT_SAT;
            evt     <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (!cfg.en) begin
                run_cnt <= CNT_SAT;
            end else if (!at_tgt) begin
                run_cnt <= '0;
            end else begin
                if (run_cnt == dbc_last(dbc_sel))
                    evt <= 1'b1;
                if (run_cnt != CNT_SAT)
                    run_cnt <= run_cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/wk_status.sv
module wk_status
    import wk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WK_SRC-1:0] hit,
    input  logic              clr,
    output logic [WK_SRC-1:0] flags
);
    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else if (clr)
            flags <= hit;
        else
            flags <= flags | hit;
    end
endmodule

// File: rtl/wk_supply_seq.sv
module wk_supply_seq
    import wk_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic core_is_on,
    input  logic sram_is_on,
    output logic core_on_req,
    output logic sram_on_req,
    output logic restart_done
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

    seq_state_t    state;
    logic [SW-1:0] settle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= SQ_IDLE;
            settle_cnt   <= '0;
            core_on_req  <= 1'b0;
            sram_on_req  <= 1'b0;
            restart_done <= 1'b0;
        end else begin
            core_on_req  <= 1'b0;
            sram_on_req  <= 1'b0;
            restart_done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (trig) begin
                        if (!core_is_on) begin
                            core_on_req <= 1'b1;
                            settle_cnt  <= '0;
                            state       <= SQ_SETTLE;
                        end else begin
                            state <= SQ_SRAM;
                        end
                    end
                end
                SQ_SETTLE: begin
                    if (settle_cnt == SETTLE_LAST)
                        state <= SQ_SRAM;
                    else
                        settle_cnt <= settle_cnt + SW'(1);
                end
                SQ_SRAM: begin
                    sram_on_req  <= !sram_is_on;
                    restart_done <= 1'b1;
                    state        <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wk_backup_ctrl.sv
module wk_backup_ctrl
    import wk_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WK_PINS-1:0]    wk_pin,
    input  logic [WK_PINS-1:0]    wk_pin_en,
    input  logic [WK_PINS-1:0]    wk_rise_sel,
    input  logic [DBC_W-1:0]      dbc_sel,
    input  logic                  rtc_alarm,
    input  logic                  rtt_alarm,
    input  logic                  sm_alarm,
    input  logic                  rtc_en,
    input  logic                  rtt_en,
    input  logic                  sm_en,
    input  logic                  stat_clr,
    input  logic                  core_is_on,
    input  logic                  sram_is_on,
    output logic [WK_SRC-1:0]     wake_status,
    output logic                  core_on_req,
    output logic                  sram_on_req,
    output logic                  restart_done
);
    logic [WK_PINS-1:0] pin_evt;
    alarm_vec_t         alarm_raw, alarm_gate, alarm_hit;
    logic [WK_SRC-1:0]  hit;

    for (genvar i = 0; i < WK_PINS; i++) begin : g_pin
        pin_cfg_t cfg;
        assign cfg = '{en: wk_pin_en[i], rise: wk_rise_sel[i]};
        wk_pin_qual u_qual (
            .clk     (clk),
            .rst     (rst),
            .pin     (wk_pin[i]),
            .cfg     (cfg),
            .dbc_sel (dbc_sel),
            .evt     (pin_evt[i])
        );
    end

    assign alarm_raw  = '{sm: sm_alarm, rtt: rtt_alarm, rtc: rtc_alarm};
    assign alarm_gate = '{sm: sm_en, rtt: rtt_en, rtc: rtc_en};
    assign alarm_hit  = alarm_raw & alarm_gate;
    assign hit        = {alarm_hit, pin_evt};

    wk_status u_status (
        .clk   (clk),
        .rst   (rst),
        .hit   (hit),
        .clr   (stat_clr),
        .flags (wake_status)
    );

    wk_supply_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .trig         (|hit),
        .core_is_on   (core_is_on),
        .sram_is_on   (sram_is_on),
        .core_on_req  (core_on_req),
        .sram_on_req  (sram_on_req),
        .restart_done (restart_done)
    );
endmodule

// File: rtl/wk_backup_chk.sv
module wk_backup_chk
    import wk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rtc_alarm,
    input logic              rtt_alarm,
    input logic              sm_alarm,
    input logic              rtc_en,
    input logic              rtt_en,
    input logic              sm_en,
    input logic              stat_clr,
    input logic              core_is_on,
    input logic              sram_is_on,
    input logic [WK_SRC-1:0] wake_status,
    input logic              core_on_req,
    input logic              sram_on_req,
    input logic              restart_done
);
    p_reset_clean_r1: assert property (@(posedge clk)
        rst |=> (wake_status == '0 && !core_on_req && !sram_on_req && !restart_done));

    p_rtc_gated_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_status[WK_PINS]) |-> $past(rtc_en && rtc_alarm));

    p_rtt_gated_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_status[WK_PINS+1]) |-> $past(rtt_en && rtt_alarm));

    p_sm_gated_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_status[WK_PINS+2]) |-> $past(sm_en && sm_alarm));

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !stat_clr |=> ((wake_status & $past(wake_status)) == $past(wake_status)));

    p_sram_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        sram_on_req |-> restart_done);

    p_core_skip_r10: assert property (@(posedge clk) disable iff (rst)
        core_on_req |-> !$past(core_is_on));

    p_sram_skip_r10: assert property (@(posedge clk) disable iff (rst)
        sram_on_req |-> !$past(sram_is_on));

    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        restart_done |=> !restart_done);
endmodule

bind wk_backup_ctrl wk_backup_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .rtc_alarm    (rtc_alarm),
    .rtt_alarm    (rtt_alarm),
    .sm_alarm     (sm_alarm),
    .rtc_en       (rtc_en),
    .rtt_en       (rtt_en),
    .sm_en        (sm_en),
    .stat_clr     (stat_clr),
    .core_is_on   (core_is_on),
    .sram_is_on   (sram_is_on),
    .wake_status  (wake_status),
    .core_on_req  (core_on_req),
    .sram_on_req  (sram_on_req),
    .restart_done (restart_done)
);

// File: tb/tb_wk_backup_ctrl.sv
`timescale 1ns/1ps
module tb_wk_backup_ctrl;
    localparam int SETTLE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] wk_pin = '0, wk_pin_en = '0, wk_rise_sel = '0;
    logic [2:0]  dbc_sel = '0;
    logic        rtc_alarm = 0, rtt_alarm = 0, sm_alarm = 0;
    logic        rtc_en = 0, rtt_en = 0, sm_en = 0;
    logic        stat_clr = 0, core_is_on = 0, sram_is_on = 0;
    logic [18:0] wake_status;
    logic        core_on_req, sram_on_req, restart_done;

    always #2.5 clk = ~clk;

    wk_backup_ctrl #(.SETTLE_CYC(SETTLE)) dut (
        .clk(clk), .rst(rst), .wk_pin(wk_pin), .wk_pin_en(wk_pin_en),
        .wk_rise_sel(wk_rise_sel), .dbc_sel(dbc_sel),
        .rtc_alarm(rtc_alarm), .rtt_alarm(rtt_alarm), .sm_alarm(sm_alarm),
        .rtc_en(rtc_en), .rtt_en(rtt_en), .sm_en(sm_en),
        .stat_clr(stat_clr), .core_is_on(core_is_on), .sram_is_on(sram_is_on),
        .wake_status(wake_status), .core_on_req(core_on_req),
        .sram_on_req(sram_on_req), .restart_done(restart_done)
    );

    int n_chk = 0, n_bad = 0;
    int n_core = 0, n_sram = 0, n_done = 0;
    bit finished = 0;

    // behavioural reference: run lengths per pin, sticky flags, sequence phase
    int          m_run[16];
    bit [15:0]   m_evt;
    bit [18:0]   m_stat;
    int          m_phase;   // 0 waiting, 1 settling, 2 finishing
    int          m_wait;
    bit          m_core, m_sram, m_done;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_run[k]) m_run[k] = 1000;
            m_evt = '0; m_stat = '0; m_phase = 0; m_wait = 0;
            m_core = 0; m_sram = 0; m_done = 0;
        end else begin
            bit [18:0] ev;
            ev = {sm_alarm & sm_en, rtt_alarm & rtt_en, rtc_alarm & rtc_en, m_evt};
            m_stat = stat_clr ? ev : (m_stat | ev);
            m_core = 0; m_sram = 0; m_done = 0;
            if (m_phase == 0) begin
                if (ev != 0) begin
                    if (!core_is_on) begin m_core = 1; m_phase = 1; m_wait = 0; end
                    else m_phase = 2;
                end
            end else if (m_phase == 1) begin
                m_wait++;
                if (m_wait == SETTLE) m_phase = 2;
            end else begin
                m_sram = !sram_is_on; m_done = 1; m_phase = 0;
            end
            for (int k = 0; k < 16; k++) begin
                m_evt[k] = 0;
                if (!wk_pin_en[k]) m_run[k] = 1000;
                else if (wk_pin[k] != wk_rise_sel[k]) m_run[k] = 0;
                else begin
                    m_run[k]++;
                    if (m_run[k] == (1 << dbc_sel)) m_evt[k] = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            n_chk++;
            if (wake_status !== m_stat) begin
                n_bad++;
                $display("FAIL R8 model wake_status act=%h exp=%h t=%0t", wake_status, m_stat, $time);
            end
            if (core_on_req !== m_core) begin
                n_bad++;
                $display("FAIL R9 model core_on_req act=%b exp=%b t=%0t", core_on_req, m_core, $time);
            end
            if (sram_on_req !== m_sram || restart_done !== m_done) begin
                n_bad++;
                $display("FAIL R10 model sram/done act=%b%b exp=%b%b t=%0t",
                         sram_on_req, restart_done, m_sram, m_done, $time);
            end
            if (core_on_req) n_core++;
            if (sram_on_req) n_sram++;
            if (restart_done) n_done++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_status;
        stat_clr = 1; cyc(1); stat_clr = 0; cyc(1);
    endtask

    initial begin
        int d0, c0, s0;
        cyc(4);
        chk("R1 status after reset", int'(wake_status), 0);
        chk("R1 core req after reset", int'(core_on_req), 0);
        rst = 0;
        cyc(1);
        chk("R1 status out of reset", int'(wake_status), 0);
        chk("R1 done out of reset", int'(restart_done), 0);

        // R2 rising edge, no debounce
        wk_pin_en[3] = 1; wk_rise_sel[3] = 1; cyc(3);
        wk_pin[3] = 1; cyc(12);
        chk("R2 rising sets bit3", int'(wake_status[3]), 1);
        chk("R9 one core request", n_core, 1);
        chk("R9 one sram request", n_sram, 1);
        chk("R9 one done", n_done, 1);
        clear_status;
        chk("R8 clear strobe", int'(wake_status), 0);
        cyc(5);
        chk("R5 held pin no refire", int'(wake_status), 0);

        // R3 falling edge; pin already low at enable
        wk_pin_en[5] = 1; wk_rise_sel[5] = 0; cyc(5);
        chk("R5 already at level", int'(wake_status[5]), 0);
        wk_pin[5] = 1; cyc(3);
        chk("R3 rise ignored for falling", int'(wake_status[5]), 0);
        wk_pin[5] = 0; cyc(12);
        chk("R3 falling sets bit5", int'(wake_status[5]), 1);
        chk("R9 second done", n_done, 2);
        clear_status;

        // R4 debounce of 8 samples
        dbc_sel = 3; wk_pin_en[7] = 1; wk_rise_sel[7] = 1; cyc(2);
        wk_pin[7] = 1; cyc(5); wk_pin[7] = 0; cyc(4);
        chk("R4 short pulse rejected", int'(wake_status[7]), 0);
        wk_pin[7] = 1; cyc(7);
        chk("R4 not yet accepted", int'(wake_status[7]), 0);
        cyc(2);
        chk("R4 accepted after 8", int'(wake_status[7]), 1);
        cyc(12); clear_status; dbc_sel = 0;

        // R7 disabled sources
        d0 = n_done;
        wk_pin[9] = 1; cyc(2); wk_pin[9] = 0; cyc(2); wk_pin[9] = 1; cyc(2);
        rtc_alarm = 1; cyc(3); rtc_alarm = 0; cyc(3);
        chk("R7 disabled no status", int'(wake_status), 0);
        chk("R7 disabled no restart", n_done, d0);

        // R6 alarms
        rtt_en = 1; rtt_alarm = 1; cyc(1); rtt_alarm = 0; cyc(12);
        chk("R6 rtt bit17", int'(wake_status[17]), 1);
        chk("R6 rtt restart", n_done, d0 + 1);
        rtc_en = 1; rtc_alarm = 1; cyc(1); rtc_alarm = 0; cyc(12);
        chk("R6 rtc bit16", int'(wake_status[16]), 1);
        clear_status;

        // R10 supplies already on
        c0 = n_core; s0 = n_sram; d0 = n_done;
        core_is_on = 1; sm_en = 1; sm_alarm = 1; cyc(1); sm_alarm = 0; cyc(12);
        chk("R6 sm bit18", int'(wake_status[18]), 1);
        chk("R10 core skipped", n_core, c0);
        chk("R10 sram still requested", n_sram, s0 + 1);
        chk("R10 done core on", n_done, d0 + 1);
        sram_is_on = 1; rtt_alarm = 1; cyc(1); rtt_alarm = 0; cyc(12);
        chk("R10 sram skipped", n_sram, s0 + 1);
        chk("R10 done both on", n_done, d0 + 2);
        core_is_on = 0; sram_is_on = 0; clear_status;

        // R11 event during sequence
        c0 = n_core; d0 = n_done;
        rtt_alarm = 1; cyc(1); rtt_alarm = 0; cyc(2);
        sm_alarm = 1; cyc(1); sm_alarm = 0; cyc(15);
        chk("R11 single done", n_done, d0 + 1);
        chk("R11 single core req", n_core, c0 + 1);
        chk("R11 status both", int'(wake_status[18:17]), 3);
        cyc(5); clear_status;

        // R8 set wins over clear
        sm_alarm = 1; cyc(1); stat_clr = 1; cyc(1); stat_clr = 0; sm_alarm = 0; cyc(1);
        chk("R8 set wins same edge", int'(wake_status[18]), 1);
        cyc(12);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule